// File: doc/BRIEF.md
# UART Configuration and Mode Controller

This block is the register front end of a serial controller run as a UART. Software reaches it through single-cycle 32-bit word reads and writes. It keeps the frame-format control word, the two halves of the baud divisor and a few general control bits. It drives these values as steady configuration outputs to a separate frame engine. In the other direction, it collects that engine's receive-ready and transmit-done events as sticky flags and turns them into one registered interrupt line.

Configuration is protected by an initialization handshake. Software raises an init request bit and then polls a state field until it reports init mode. Only then does it rewrite the frame format or the divisor, and afterwards it drops the request again. The control word has its own mode-select bit. That bit has to be set by one write before any later write can load the other fields. The receive and transmit enables are the one exception to the init rule: they can be changed while traffic runs.

Top module: `uart_cfg_ctrl`

## Requirements
- R1: After reset the state field (status offset 0x08, bits 15:12) reads 4'b0001 (init). Offset 0x00 reads 0x1. Offsets 0x04, 0x10 and 0x14 read 0. The interrupt output is low.
- R2: The state field follows bit 0 of offset 0x00 two clock edges after the write that changes it. It reads 4'b0001 in init mode and 4'b0010 in normal mode. After one edge it still shows the old value.
- R3: While bit 0 of the control word (offset 0x10) is 0, a write can change only that bit, and only in init mode.
- R4: In init mode with bit 0 already set, a write loads all ten control bits 9:0 and bits 31:10 read 0. The fields are: bit 0 mode, bits 7 and 1 word length, bit 2 parity enable, bits 6 and 3 parity type, bit 4 transmit enable, bit 5 receive enable, bit 8 transmit FIFO mode, bit 9 receive FIFO mode.
- R5: Outside init mode, with bit 0 set, a control-word write changes only bits 4 and 5.
- R6: The integer divisor (offset 0x28) and the 4-bit fractional divisor (offset 0x24) are written only in init mode. The divisor output equals integer*16 + fraction.
- R7: Bits 4 and 7 of offset 0x00 read and write at any time and drive the master and filter-bypass outputs.
- R8: A receive-ready event sets status bit 2 of offset 0x14, and a transmit-done event sets status bit 1. Writing 1 to a bit clears it. An event in the same cycle as the clear wins.
- R9: The interrupt is high one cycle after any flag is set whose enable bit is set. Offset 0x04 holds the enables: bit 2 for receive and bit 1 for transmit. Other bits read 0.
- R10: A write to offset 0x38 while transmit enable is set gives a one-cycle transmit-load pulse in the next cycle, carrying the low byte. Such a write is ignored when transmit enable is clear.
- R11: A read of offset 0x3C returns the receive byte input in bits 7:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 8 | Byte offset of the word accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |
| rx_evt | input | 1 | Receive-ready pulse from the frame engine |
| tx_evt | input | 1 | Transmit-done pulse from the frame engine |
| rx_byte | input | 8 | Last received character |
| tx_load | output | 1 | One-cycle pulse that hands a byte to the transmitter |
| tx_byte | output | 8 | Byte to send |
| cfg_uart | output | 1 | UART mode selected |
| cfg_word_len | output | 2 | Word length code {bit7, bit1} |
| cfg_par_en | output | 1 | Parity enable |
| cfg_par_type | output | 2 | Parity type {bit6, bit3} |
| cfg_tx_en | output | 1 | Transmitter enable |
| cfg_rx_en | output | 1 | Receiver enable |
| cfg_tx_fifo | output | 1 | Transmit FIFO mode instead of buffer mode |
| cfg_rx_fifo | output | 1 | Receive FIFO mode instead of buffer mode |
| cfg_master | output | 1 | Master mode |
| cfg_bypass | output | 1 | Input filter bypass |
| cfg_in_init | output | 1 | Block is in init mode |
| baud_div | output | 24 | Divisor in 1/16 bit units: {integer, fraction} |
| irq | output | 1 | Registered interrupt request |

## Verification
The embedded properties assume that each write lasts exactly one cycle, that offsets are word aligned, and that the frame-engine events are single-cycle pulses. The stimulus drives every input on the falling edge and holds each write strobe for one cycle only. It raises each event for one cycle, and it places a clear and an event in the same cycle only in the deliberate set-wins case. Write-guard properties compare register contents across one edge against the init state seen at that edge. The stimulus therefore moves in and out of init mode only through the control register, which lets those properties see every transition.

// File: rtl/ucc_pkg.sv
package ucc_pkg;
  localparam logic [7:0] OFS_CTL1  = 8'h00;
  localparam logic [7:0] OFS_IEN   = 8'h04;
  localparam logic [7:0] OFS_STATE = 8'h08;
  localparam logic [7:0] OFS_UCTL  = 8'h10;
  localparam logic [7:0] OFS_USTAT = 8'h14;
  localparam logic [7:0] OFS_BFRAC = 8'h24;
  localparam logic [7:0] OFS_BINT  = 8'h28;
  localparam logic [7:0] OFS_TXD   = 8'h38;
  localparam logic [7:0] OFS_RXD   = 8'h3C;

  localparam logic [3:0] ST_INIT = 4'b0001;
  localparam logic [3:0] ST_RUN  = 4'b0010;

  localparam int UCTL_W = 10;

  // control word, bit 9 down to bit 0
  typedef struct packed {
    logic rx_fifo;
    logic tx_fifo;
    logic wl_hi;
    logic pt_hi;
    logic rx_en;
    logic tx_en;
    logic pt_lo;
    logic par_en;
    logic wl_lo;
    logic uart;
  } uctl_t;
endpackage

// File: rtl/ucc_init_seq.sv
module ucc_init_seq #(
  parameter int LAG = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req,
  output logic in_init
);
  logic [LAG-1:0] chain_q, chain_d;
  logic [LAG:0]   shifted;

  always_comb begin
    shifted = {chain_q, req};
    chain_d = shifted[LAG-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '1;
    else        chain_q <= chain_d;
  end

  assign in_init = chain_q[LAG-1];

  // R2
  init_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(in_init) |-> $past(req));
  // R2
  init_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(in_init) |-> !$past(req));
endmodule

// File: rtl/ucc_mode_regs.sv
module ucc_mode_regs
  import ucc_pkg::*;
#(
  parameter int INT_W  = 20,
  parameter int FRAC_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_init,
  input  logic              wr_ctl,
  input  logic              wr_int,
  input  logic              wr_frac,
  input  logic [UCTL_W-1:0] wdata_ctl,
  input  logic [INT_W-1:0]  wdata_int,
  input  logic [FRAC_W-1:0] wdata_frac,
  output uctl_t             uctl,
  output logic [INT_W-1:0]  baud_int,
  output logic [FRAC_W-1:0] baud_frac
);
  uctl_t             uctl_q, uctl_d;
  logic [INT_W-1:0]  int_q;
  logic [FRAC_W-1:0] frac_q;
  logic              ld_int, ld_frac;

  always_comb begin
    uctl_d = uctl_q;
    if (wr_ctl) begin
      if (in_init) begin
        if (uctl_q.uart) uctl_d = uctl_t'(wdata_ctl);
        else             uctl_d.uart = wdata_ctl[0];
      end else if (uctl_q.uart) begin
        uctl_d.tx_en = wdata_ctl[4];
        uctl_d.rx_en = wdata_ctl[5];
      end
    end
    ld_int  = wr_int  && in_init;
    ld_frac = wr_frac && in_init;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      uctl_q <= '0;
      int_q  <= '0;
      frac_q <= '0;
    end else begin
      uctl_q <= uctl_d;
      if (ld_int)  int_q  <= wdata_int;
      if (ld_frac) frac_q <= wdata_frac;
    end
  end

  assign uctl      = uctl_q;
  assign baud_int  = int_q;
  assign baud_frac = frac_q;

  // R3
  mode_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !uctl_q.uart |=> $stable(uctl_q[UCTL_W-1:1]));
  // R5
  run_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_init |=> ($stable(uctl_q[3:0]) && $stable(uctl_q[9:6])));
  // R6
  baud_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_init |=> ($stable(int_q) && $stable(frac_q)));
endmodule

// File: rtl/ucc_irq.sv
module ucc_irq (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rx_evt,
  input  logic       tx_evt,
  input  logic       clr_wr,
  input  logic [1:0] clr_mask,
  input  logic [1:0] en,
  output logic [1:0] flags,
  output logic       irq
);
  logic [1:0] flags_q, flags_d;
  logic       irq_q, irq_d;

  always_comb begin
    flags_d = flags_q & ~(clr_wr ? clr_mask : 2'b00);
    flags_d = flags_d | {rx_evt, tx_evt};
    irq_d   = |(flags_q & en);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
      irq_q   <= 1'b0;
    end else begin
      flags_q <= flags_d;
      irq_q   <= irq_d;
    end
  end

  assign flags = flags_q;
  assign irq   = irq_q;

  // R8
  rx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_evt |=> flags_q[1]);
  // R8
  tx_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    tx_evt |=> flags_q[0]);
  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (|(flags_q & en)) |=> irq_q);
endmodule

// File: rtl/uart_cfg_ctrl.sv
module uart_cfg_ctrl
  import ucc_pkg::*;
#(
  parameter int INT_W    = 20,
  parameter int OSR      = 16,
  parameter int INIT_LAG = 2,
  localparam int FRAC_W  = $clog2(OSR)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [7:0]              bus_addr,
  input  logic [31:0]             bus_wdata,
  output logic [31:0]             bus_rdata,
  input  logic                    rx_evt,
  input  logic                    tx_evt,
  input  logic [7:0]              rx_byte,
  output logic                    tx_load,
  output logic [7:0]              tx_byte,
  output logic                    cfg_uart,
  output logic [1:0]              cfg_word_len,
  output logic                    cfg_par_en,
  output logic [1:0]              cfg_par_type,
  output logic                    cfg_tx_en,
  output logic                    cfg_rx_en,
  output logic                    cfg_tx_fifo,
  output logic                    cfg_rx_fifo,
  output logic                    cfg_master,
  output logic                    cfg_bypass,
  output logic                    cfg_in_init,
  output logic [INT_W+FRAC_W-1:0] baud_div,
  output logic                    irq
);
  logic       rst_meta, rst_s;
  logic       req_q, master_q, bypass_q;
  logic       req_d, master_d, bypass_d, ld_ctl1;
  logic [1:0] ien_q, ien_d;
  logic       ld_ien;
  logic       txl_q, txl_d;
  logic [7:0] txb_q, txb_d;
  logic       wr_ctl1, wr_ien, wr_uctl, wr_ustat, wr_int, wr_frac, wr_txd;
  logic       in_init;
  uctl_t      uctl;
  logic [INT_W-1:0]  baud_int;
  logic [FRAC_W-1:0] baud_frac;
  logic [1:0] flags;

  // reset asserted at once, released on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_s    <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_s    <= rst_meta;
    end
  end

  always_comb begin
    wr_ctl1  = bus_wr && (bus_addr == OFS_CTL1);
    wr_ien   = bus_wr && (bus_addr == OFS_IEN);
    wr_uctl  = bus_wr && (bus_addr == OFS_UCTL);
    wr_ustat = bus_wr && (bus_addr == OFS_USTAT);
    wr_int   = bus_wr && (bus_addr == OFS_BINT);
    wr_frac  = bus_wr && (bus_addr == OFS_BFRAC);
    wr_txd   = bus_wr && (bus_addr == OFS_TXD);
    ld_ctl1  = wr_ctl1;
    req_d    = bus_wdata[0];
    master_d = bus_wdata[4];
    bypass_d = bus_wdata[7];
    ld_ien   = wr_ien;
    ien_d    = bus_wdata[2:1];
    txl_d    = wr_txd && uctl.tx_en;
    txb_d    = txl_d ? bus_wdata[7:0] : txb_q;
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      req_q    <= 1'b1;
      master_q <= 1'b0;
      bypass_q <= 1'b0;
      ien_q    <= '0;
      txl_q    <= 1'b0;
      txb_q    <= '0;
    end else begin
      if (ld_ctl1) begin
        req_q    <= req_d;
        master_q <= master_d;
        bypass_q <= bypass_d;
      end
      if (ld_ien) ien_q <= ien_d;
      txl_q <= txl_d;
      txb_q <= txb_d;
    end
  end

  ucc_init_seq #(.LAG(INIT_LAG)) u_init (
    .clk(clk), .rst_n(rst_s), .req(req_q), .in_init(in_init)
  );

  ucc_mode_regs #(.INT_W(INT_W), .FRAC_W(FRAC_W)) u_regs (
    .clk(clk), .rst_n(rst_s), .in_init(in_init),
    .wr_ctl(wr_uctl), .wr_int(wr_int), .wr_frac(wr_frac),
    .wdata_ctl(bus_wdata[UCTL_W-1:0]), .wdata_int(bus_wdata[INT_W-1:0]),
    .wdata_frac(bus_wdata[FRAC_W-1:0]),
    .uctl(uctl), .baud_int(baud_int), .baud_frac(baud_frac)
  );

  ucc_irq u_irq (
    .clk(clk), .rst_n(rst_s), .rx_evt(rx_evt), .tx_evt(tx_evt),
    .clr_wr(wr_ustat), .clr_mask(bus_wdata[2:1]), .en(ien_q),
    .flags(flags), .irq(irq)
  );

  always_comb begin
    bus_rdata = '0;
    case (bus_addr)
      OFS_CTL1:  bus_rdata = {24'b0, bypass_q, 2'b0, master_q, 3'b0, req_q};
      OFS_IEN:   bus_rdata = {29'b0, ien_q, 1'b0};
      OFS_STATE: bus_rdata = {16'b0, (in_init ? ST_INIT : ST_RUN), 12'b0};
      OFS_UCTL:  bus_rdata = {{(32-UCTL_W){1'b0}}, uctl};
      OFS_USTAT: bus_rdata = {29'b0, flags, 1'b0};
      OFS_BFRAC: bus_rdata = {{(32-FRAC_W){1'b0}}, baud_frac};
      OFS_BINT:  bus_rdata = {{(32-INT_W){1'b0}}, baud_int};
      OFS_RXD:   bus_rdata = {24'b0, rx_byte};
      default:   bus_rdata = '0;
    endcase
  end

  assign tx_load      = txl_q;
  assign tx_byte      = txb_q;
  assign cfg_uart     = uctl.uart;
  assign cfg_word_len = {uctl.wl_hi, uctl.wl_lo};
  assign cfg_par_en   = uctl.par_en;
  assign cfg_par_type = {uctl.pt_hi, uctl.pt_lo};
  assign cfg_tx_en    = uctl.tx_en;
  assign cfg_rx_en    = uctl.rx_en;
  assign cfg_tx_fifo  = uctl.tx_fifo;
  assign cfg_rx_fifo  = uctl.rx_fifo;
  assign cfg_master   = master_q;
  assign cfg_bypass   = bypass_q;
  assign cfg_in_init  = in_init;
  assign baud_div     = {baud_int, baud_frac};

  // R10
  tx_gate_chk: assert property (@(posedge clk) disable iff (!rst_s)
    tx_load |-> cfg_tx_en);
endmodule

// File: tb/uart_cfg_ctrl_bench.sv
module uart_cfg_ctrl_bench;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_wr;
  logic [7:0]  bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic        rx_evt, tx_evt;
  logic [7:0]  rx_byte, tx_byte;
  logic        tx_load, cfg_uart, cfg_par_en, cfg_tx_en, cfg_rx_en;
  logic        cfg_tx_fifo, cfg_rx_fifo, cfg_master, cfg_bypass, cfg_in_init, irq;
  logic [1:0]  cfg_word_len, cfg_par_type;
  logic [23:0] baud_div;
  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  uart_cfg_ctrl u_uart_cfg_ctrl (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_evt(rx_evt),
    .tx_evt(tx_evt), .rx_byte(rx_byte), .tx_load(tx_load), .tx_byte(tx_byte),
    .cfg_uart(cfg_uart), .cfg_word_len(cfg_word_len), .cfg_par_en(cfg_par_en),
    .cfg_par_type(cfg_par_type), .cfg_tx_en(cfg_tx_en), .cfg_rx_en(cfg_rx_en),
    .cfg_tx_fifo(cfg_tx_fifo), .cfg_rx_fifo(cfg_rx_fifo),
    .cfg_master(cfg_master), .cfg_bypass(cfg_bypass),
    .cfg_in_init(cfg_in_init), .baud_div(baud_div), .irq(irq)
  );

  // {offset, write data, expected read-back} walked in init mode
  localparam int NV = 8;
  localparam logic [71:0] VEC [NV] = '{
    {8'h10, 32'h0000_03FE, 32'h0000_0000},  // R3 mode bit clear
    {8'h10, 32'h0000_0001, 32'h0000_0001},  // R3 set mode bit
    {8'h10, 32'hFFFF_FFFF, 32'h0000_03FF},  // R4 all fields
    {8'h10, 32'h0000_0023, 32'h0000_0023},  // R4 8 bit, rx on
    {8'h28, 32'h0000_001A, 32'h0000_001A},  // R6 integer part
    {8'h24, 32'h0000_00FB, 32'h0000_000B},  // R6 fraction, 4 bits
    {8'h04, 32'h0000_FFFF, 32'h0000_0006},  // R9 enables only
    {8'h00, 32'h0000_0091, 32'h0000_0091}   // R7 master, bypass, init
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  initial begin
    #(5.0 * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] v;
    rst_n = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    rx_evt = 1'b0; tx_evt = 1'b0; rx_byte = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(8'h08, v); chk("R1 state", v, 32'h0000_1000);
    rd(8'h00, v); chk("R1 ctl1", v, 32'h1);
    rd(8'h04, v); chk("R1 ien", v, 32'h0);
    rd(8'h10, v); chk("R1 uctl", v, 32'h0);
    rd(8'h14, v); chk("R1 ustat", v, 32'h0);
    chk("R1 irq", {31'b0, irq}, 32'h0);

    for (int i = 0; i < NV; i++) begin
      wr(VEC[i][71:64], VEC[i][63:32]);
      rd(VEC[i][71:64], v);
      chk("R3 R4 R6 R7 R9 table", v, VEC[i][31:0]);
    end
    chk("R7 outputs", {30'b0, cfg_master, cfg_bypass}, 32'h3);
    chk("R4 outputs", {24'b0, cfg_word_len, cfg_par_en, cfg_rx_en, cfg_tx_en, cfg_uart, 2'b0},
        {24'b0, 2'b01, 1'b0, 1'b1, 1'b0, 1'b1, 2'b0});

    // R2 leave init, two edges
    wr(8'h00, 32'h90);
    rd(8'h08, v); chk("R2 exit hold", v, 32'h0000_1000);
    @(negedge clk); rd(8'h08, v); chk("R2 exit hold2", v, 32'h0000_1000);
    @(negedge clk); rd(8'h08, v); chk("R2 exit done", v, 32'h0000_2000);

    // R5 only enables change in normal mode
    wr(8'h10, 32'h0000_0011);
    rd(8'h10, v); chk("R5 uctl", v, 32'h0000_0013);
    // R6 baud locked in normal mode
    wr(8'h28, 32'h55);
    rd(8'h28, v); chk("R6 int locked", v, 32'h1A);
    chk("R6 divisor", {8'b0, baud_div}, 32'h0000_01AB);

    // R10 transmit pulse
    wr(8'h38, 32'h1234_56A5);
    chk("R10 pulse", {23'b0, tx_load, tx_byte}, {23'b0, 1'b1, 8'hA5});
    @(negedge clk); chk("R10 pulse end", {31'b0, tx_load}, 32'h0);
    wr(8'h10, 32'h0000_0001);
    rd(8'h10, v); chk("R5 tx off", v, 32'h0000_0003);
    wr(8'h38, 32'h77);
    chk("R10 ignored", {31'b0, tx_load}, 32'h0);
    @(negedge clk); chk("R10 ignored2", {31'b0, tx_load}, 32'h0);

    // R11 receive byte
    rx_byte = 8'h3C;
    rd(8'h3C, v); chk("R11 rxd", v, 32'h3C);

    // R8 R9 flags and irq
    @(negedge clk); rx_evt = 1'b1;
    @(negedge clk); rx_evt = 1'b0;
    rd(8'h14, v); chk("R8 rx flag", v, 32'h4);
    chk("R9 irq lag", {31'b0, irq}, 32'h0);
    @(negedge clk); chk("R9 irq high", {31'b0, irq}, 32'h1);
    wr(8'h14, 32'h4);
    rd(8'h14, v); chk("R8 clear", v, 32'h0);
    @(negedge clk); chk("R9 irq low", {31'b0, irq}, 32'h0);
    @(negedge clk);
    tx_evt = 1'b1; bus_wr = 1'b1; bus_addr = 8'h14; bus_wdata = 32'h2;
    @(negedge clk);
    tx_evt = 1'b0; bus_wr = 1'b0;
    rd(8'h14, v); chk("R8 set wins", v, 32'h2);
    wr(8'h04, 32'h0);
    wr(8'h14, 32'h2);
    @(negedge clk); @(negedge clk);
    chk("R9 masked", {31'b0, irq}, 32'h0);

    // R2 re-enter init
    wr(8'h00, 32'h1);
    rd(8'h08, v); chk("R2 entry hold", v, 32'h0000_2000);
    @(negedge clk); rd(8'h08, v); chk("R2 entry hold2", v, 32'h0000_2000);
    @(negedge clk); rd(8'h08, v); chk("R2 entry done", v, 32'h0000_1000);
    chk("R7 cleared", {30'b0, cfg_master, cfg_bypass}, 32'h0);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule